// File: doc/BRIEF.md
# Video DAC Code Level Encoder

This block turns three 8-bit pixel components into the unsigned integer codes that feed a three-channel video DAC. For each channel it can add a black pedestal. It replaces active data with a blanking level when the line is blanked. On one chosen channel it also adds the sync offset that lifts the blanking level above the sync tip.

A mode input selects one of two colour spaces. In GBR mode the three channels carry green, blue and red. Only green carries sync, and blue and red fall to zero while blanked. In luminance/chrominance mode the channels carry Y, Cb and Cr. Y carries sync, and both chroma channels sit at the zero-chroma midpoint of 128 while blanked. Chroma data arrives in offset-binary form, so 128 means no colour.

Every input is sampled on the pixel clock, and the three codes are registered. The block is placed directly ahead of the DAC.

Top module: `vdac_level_enc`

## Requirements
- R1: Each code output is registered and shows the result for the inputs sampled on the previous rising clock edge. A synchronous active-high `rst` clears all three codes to 0.
- R2: When `setup_en`=1 and `blank_n`=1, each channel's code includes its data plus a pedestal of 21. When `setup_en`=0, no pedestal is added.
- R3: Channel 0 is the sync-carrying channel (green in GBR mode, luma in luminance/chrominance mode). It adds 110 whenever `sync_n`=1, so its blanked code is 110 and its sync-tip code (`blank_n`=0, `sync_n`=0) is 0.
- R4: While `blank_n`=0, neither data nor pedestal reaches any channel. `setup_en` and the data inputs have no effect on the codes.
- R5: With `mode_yc`=1 (luminance/chrominance), channels 1 and 2 output exactly 128 while `blank_n`=0.
- R6: With `mode_yc`=0 (GBR), channels 1 and 2 output 0 while `blank_n`=0.
- R7: Channels 1 and 2 never include the sync offset. `sync_n` has no effect on them in either mode.
- R8: No code exceeds 386. Data 255 with pedestal and sync on channel 0 yields exactly 386.
- R9: During active video (`blank_n`=1), `mode_yc` has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_yc | input | 1 | 0 = GBR, 1 = luminance/chrominance |
| setup_en | input | 1 | Pedestal enable |
| blank_n | input | 1 | 0 = blanked line/pixel |
| sync_n | input | 1 | 0 = sync tip |
| ch0_data | input | 8 | Green or luma data |
| ch1_data | input | 8 | Blue or Cb data |
| ch2_data | input | 8 | Red or Cr data |
| ch0_code | output | 9 | DAC code, sync-carrying channel |
| ch1_code | output | 9 | DAC code, channel 1 |
| ch2_code | output | 9 | DAC code, channel 2 |

## Verification
Each code has one register between the inputs and the port, so every result is due on the first rising edge after the stimulus is applied. The bench changes inputs on the falling edge and samples the codes 2 ns after the next rising edge. To cover the latency, one scenario checks that the previous code still holds just before that edge, after new inputs have already been applied. Blanking, sync and mode cases are each checked at that same single-cycle point.

// File: rtl/vdac_level_pkg.sv
package vdac_level_pkg;

   typedef enum logic {
      MODE_GBR = 1'b0,
      MODE_YC  = 1'b1
   } vdac_mode_e;

   function automatic int code_max(input int data_w, input int ped, input int sync_lvl);
      return (2 ** data_w) - 1 + ped + sync_lvl;
   endfunction

endpackage

// File: rtl/vdac_lvl_ctrl.sv
module vdac_lvl_ctrl
   import vdac_level_pkg::*;
#(
   parameter int NUM_CH     = 3,
   parameter int CODE_W     = 9,
   parameter int SYNC_CHAN  = 0,
   parameter int CHROMA_MID = 128
) (
   input  vdac_mode_e          mode,
   input  logic                sync_n,
   output logic [CODE_W-1:0]   fill   [NUM_CH],
   output logic [NUM_CH-1:0]   sync_add
);

   localparam logic [CODE_W-1:0] MID_C = CODE_W'(CHROMA_MID);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == SYNC_CHAN) begin : g_sync
         assign fill[c]     = '0;
         assign sync_add[c] = sync_n;
      end else begin : g_plain
         assign fill[c]     = (mode == MODE_YC) ? MID_C : '0;
         assign sync_add[c] = 1'b0;
      end
   end

endmodule

// File: rtl/vdac_chan_enc.sv
module vdac_chan_enc #(
   parameter int DATA_W   = 8,
   parameter int CODE_W   = 9,
   parameter int PED      = 21,
   parameter int SYNC_LVL = 110
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] data,
   input  logic              setup_en,
   input  logic              blank_n,
   input  logic              sync_add,
   input  logic [CODE_W-1:0] fill,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] PED_C  = CODE_W'(PED);
   localparam logic [CODE_W-1:0] SYNC_C = CODE_W'(SYNC_LVL);
   localparam int                TOP_I  = (2 ** DATA_W) - 1 + PED + SYNC_LVL;
   localparam logic [CODE_W-1:0] TOP_C  = CODE_W'(TOP_I);

   logic [CODE_W-1:0] active_v;
   logic [CODE_W-1:0] base_v;
   logic [CODE_W-1:0] code_d;

   always_comb begin
      active_v = CODE_W'(data) + (setup_en ? PED_C : '0);
      base_v   = blank_n ? active_v : fill;
      code_d   = base_v + (sync_add ? SYNC_C : '0);
   end

   always_ff @(posedge clk) begin
      if (rst) code <= '0;
      else     code <= code_d;
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> code == '0);

   // R8
   max_code_chk: assert property (@(posedge clk) disable iff (rst)
      code <= TOP_C);

   // R4
   blank_fill_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && !blank_n && !sync_add) |-> code == $past(fill));

endmodule

// File: rtl/vdac_level_enc.sv
module vdac_level_enc
   import vdac_level_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CODE_W     = 9,
   parameter int PED        = 21,
   parameter int SYNC_LVL   = 110,
   parameter int CHROMA_MID = 128,
   parameter int SYNC_CHAN  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_yc,
   input  logic              setup_en,
   input  logic              blank_n,
   input  logic              sync_n,
   input  logic [DATA_W-1:0] ch0_data,
   input  logic [DATA_W-1:0] ch1_data,
   input  logic [DATA_W-1:0] ch2_data,
   output logic [CODE_W-1:0] ch0_code,
   output logic [CODE_W-1:0] ch1_code,
   output logic [CODE_W-1:0] ch2_code
);

   localparam int NUM_CH = 3;
   localparam int TOP_I  = code_max(DATA_W, PED, SYNC_LVL);

   if (TOP_I >= (2 ** CODE_W)) begin : g_bad_width
      $error("CODE_W too narrow for data + pedestal + sync");
   end
   if (CHROMA_MID >= (2 ** CODE_W)) begin : g_bad_mid
      $error("CHROMA_MID does not fit in CODE_W");
   end
   if (SYNC_CHAN < 0 || SYNC_CHAN >= NUM_CH) begin : g_bad_sync
      $error("SYNC_CHAN out of range");
   end

   vdac_mode_e        mode_s;
   logic [DATA_W-1:0] data_a   [NUM_CH];
   logic [CODE_W-1:0] fill_a   [NUM_CH];
   logic [CODE_W-1:0] code_a   [NUM_CH];
   logic [NUM_CH-1:0] sync_add;

   assign mode_s    = vdac_mode_e'(mode_yc);
   assign data_a[0] = ch0_data;
   assign data_a[1] = ch1_data;
   assign data_a[2] = ch2_data;
   assign ch0_code  = code_a[0];
   assign ch1_code  = code_a[1];
   assign ch2_code  = code_a[2];

   vdac_lvl_ctrl #(
      .NUM_CH    (NUM_CH),
      .CODE_W    (CODE_W),
      .SYNC_CHAN (SYNC_CHAN),
      .CHROMA_MID(CHROMA_MID)
   ) ctrl_i (
      .mode    (mode_s),
      .sync_n  (sync_n),
      .fill    (fill_a),
      .sync_add(sync_add)
   );

   // R7
   one_sync_chan_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sync_add));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      vdac_chan_enc #(
         .DATA_W  (DATA_W),
         .CODE_W  (CODE_W),
         .PED     (PED),
         .SYNC_LVL(SYNC_LVL)
      ) enc_i (
         .clk     (clk),
         .rst     (rst),
         .data    (data_a[c]),
         .setup_en(setup_en),
         .blank_n (blank_n),
         .sync_add(sync_add[c]),
         .fill    (fill_a[c]),
         .code    (code_a[c])
      );

      // R2
      ped_floor_chk: assert property (@(posedge clk) disable iff (rst)
         $past(!rst && blank_n && setup_en) |-> code_a[c] >= CODE_W'(PED));

      if (c == SYNC_CHAN) begin : g_sync_chk
         // R3
         blank_level_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && !blank_n) |->
               code_a[c] == ($past(sync_n) ? CODE_W'(SYNC_LVL) : '0));
      end else begin : g_plain_chk
         // R5
         yc_mid_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && !blank_n && mode_yc) |-> code_a[c] == CODE_W'(CHROMA_MID));
         // R6
         gbr_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && !blank_n && !mode_yc) |-> code_a[c] == '0);
         // R7
         no_sync_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst && blank_n && !setup_en) |-> code_a[c] == CODE_W'($past(data_a[c])));
      end
   end

endmodule

// File: tb/vdac_level_enc_tb.sv
module vdac_level_enc_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       mode_yc, setup_en, blank_n, sync_n;
   logic [7:0] d0, d1, d2;
   logic [8:0] c0, c1, c2;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vdac_level_enc dut_i (
      .clk(clk), .rst(rst), .mode_yc(mode_yc), .setup_en(setup_en),
      .blank_n(blank_n), .sync_n(sync_n),
      .ch0_data(d0), .ch1_data(d1), .ch2_data(d2),
      .ch0_code(c0), .ch1_code(c1), .ch2_code(c2)
   );

   task automatic drive(input logic m, input logic s, input logic b, input logic y,
                        input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
      @(negedge clk);
      mode_yc = m; setup_en = s; blank_n = b; sync_n = y;
      d0 = a0; d1 = a1; d2 = a2;
   endtask

   task automatic settle();
      @(posedge clk);
      #2;
   endtask

   task automatic check3(input int e0, input int e1, input int e2, input string req);
      checks++;
      if (c0 !== 9'(e0) || c1 !== 9'(e1) || c2 !== 9'(e2)) begin
         fails++;
         $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d", req, c0, c1, c2, e0, e1, e2);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      mode_yc = 1'b1; setup_en = 1'b1; blank_n = 1'b1; sync_n = 1'b1;
      d0 = 8'hFF; d1 = 8'hFF; d2 = 8'hFF;
      settle();
      check3(0, 0, 0, "R1 reset clear");
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_latency();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'd10, 8'd20, 8'd30);
      settle();
      check3(120, 20, 30, "R1 first result");
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'd40, 8'd50, 8'd60);
      #1;
      check3(120, 20, 30, "R1 holds before edge");
      settle();
      check3(150, 50, 60, "R1 one-cycle update");
   endtask

   task automatic t_gbr_active();
      drive(1'b0, 1'b0, 1'b1, 1'b1, 8'd255, 8'd128, 8'd0);
      settle();
      check3(365, 128, 0, "R3 GBR no setup");
      drive(1'b0, 1'b1, 1'b1, 1'b1, 8'd255, 8'd128, 8'd0);
      settle();
      check3(386, 149, 21, "R2 R8 GBR setup full scale");
   endtask

   task automatic t_yc_active();
      drive(1'b1, 1'b0, 1'b1, 1'b1, 8'd64, 8'd200, 8'd10);
      settle();
      check3(174, 200, 10, "R9 YC no setup");
      drive(1'b1, 1'b1, 1'b1, 1'b1, 8'd0, 8'd0, 8'd255);
      settle();
      check3(131, 21, 276, "R2 YC setup");
      drive(1'b1, 1'b1, 1'b1, 1'b1, 8'd255, 8'd128, 8'd0);
      settle();
      check3(386, 149, 21, "R9 mode has no effect when active");
   endtask

   task automatic t_sync_active();
      drive(1'b0, 1'b0, 1'b1, 1'b0, 8'd100, 8'd50, 8'd60);
      settle();
      check3(100, 50, 60, "R7 GBR sync only on ch0");
      drive(1'b1, 1'b0, 1'b1, 1'b0, 8'd100, 8'd50, 8'd60);
      settle();
      check3(100, 50, 60, "R7 YC sync only on ch0");
   endtask

   task automatic t_blank_gbr();
      drive(1'b0, 1'b1, 1'b0, 1'b1, 8'd255, 8'd255, 8'd255);
      settle();
      check3(110, 0, 0, "R4 R6 GBR blank level");
      drive(1'b0, 1'b1, 1'b0, 1'b0, 8'd255, 8'd255, 8'd255);
      settle();
      check3(0, 0, 0, "R3 R6 GBR sync tip");
   endtask

   task automatic t_blank_yc();
      drive(1'b1, 1'b1, 1'b0, 1'b1, 8'd200, 8'd7, 8'd250);
      settle();
      check3(110, 128, 128, "R5 YC blank level");
      drive(1'b1, 1'b0, 1'b0, 1'b0, 8'd3, 8'd90, 8'd1);
      settle();
      check3(0, 128, 128, "R5 R3 YC sync tip");
      drive(1'b1, 1'b0, 1'b0, 1'b1, 8'd0, 8'd0, 8'd0);
      settle();
      check3(110, 128, 128, "R4 setup and data ignored while blanked");
   endtask

   initial begin
      rst = 1'b1; mode_yc = 1'b0; setup_en = 1'b0; blank_n = 1'b1; sync_n = 1'b1;
      d0 = '0; d1 = '0; d2 = '0;
      repeat (2) @(posedge clk);
      t_reset();
      t_latency();
      t_gbr_active();
      t_yc_active();
      t_sync_active();
      t_blank_gbr();
      t_blank_yc();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule